// File: doc/BRIEF.md
# Block-Acknowledge Transmit Window Tracker

This block keeps the transmit state of one aggregation queue that runs under a block-acknowledge window of at most 64 frames. Frames are numbered by an 8-bit ring index, which is the low byte of the frame's sequence number. The block knows three counts. The window start is the oldest frame that has not yet been acknowledged. The issue pointer marks the next frame that has never been sent. The enqueue pointer counts the frames the host has queued. For every index inside the window the block records whether the frame has finished transmission, whether the peer has acknowledged it, and whether it must be sent again.

A scheduler reads one offer each cycle and accepts it with `take_i`. The offer is either the oldest frame that waits for retransmission or, when the window has room, the next queued frame. The transmit path reports each completed transmission with a done strobe. The receive path delivers each block-ack as a start sequence number and a 64-bit bitmap. Acknowledgements may arrive out of order. The window start moves forward only over the unbroken run of acknowledged frames at its head, and the slots it leaves behind are cleared.

Top module: `baw_tracker`

## Requirements
- R1: After a synchronous active-low reset the window start, the issue pointer and the enqueue pointer are all 0 and every slot is clear. No frame is offered, and `room_o` is 1 as long as the configured window size and frame limit are both nonzero.
- R2: Each `enq_i` pulse queues one new frame. When nothing waits for retransmission, a new frame is offered while frames are queued and room is available. New frames are offered in ring order with consecutive indices. Accepting one advances the issue pointer by one.
- R3: `room_o` is 1 exactly when the number of frames in flight (the issue pointer minus the window start, modulo 256) is below both the effective window size and `frame_limit_i`. When `room_o` is 0 no new frame is offered.
- R4: For each bit i of `ba_bitmap_i`, a set bit acknowledges ring index (`ba_ssn_i` + i) mod 256, but only when that index lies inside the current window. Set bits that fall outside the window are ignored, and they leave no trace on frames admitted later.
- R5: The window start advances past every consecutive acknowledged frame at its head, in the same cycle as the acknowledgement. An acknowledged frame that sits behind an unacknowledged one does not move the window start.
- R6: A frame inside the window whose transmission has completed, that is not yet acknowledged, and whose bit is 0 in a block-ack that covers its index is marked for retransmission. Retransmissions are offered with `offer_retry_o` = 1, ahead of any new frame and oldest first. Accepting a retransmission makes the frame wait for a new transmit-done report.
- R7: A zero bit has no effect on a frame whose transmission has not been reported done. It also has no effect on a frame that is already acknowledged.
- R8: All indices, the window start and the pointers wrap modulo 256.
- R9: A window size above 64 is treated as 64. A window size of 0 admits no new frame.
- R10: A transmit-done report whose index lies outside the current window is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| win_size_i | input | 7 | Configured window size in frames (values above 64 are clamped) |
| frame_limit_i | input | 7 | Maximum number of frames in flight |
| enq_i | input | 1 | One new frame queued by the host |
| take_i | input | 1 | Scheduler accepts the current offer |
| txd_valid_i | input | 1 | Transmit-done report strobe |
| txd_idx_i | input | 8 | Ring index of the frame whose transmission completed |
| ba_valid_i | input | 1 | Block-ack event strobe |
| ba_ssn_i | input | 8 | Start sequence index of the block-ack bitmap |
| ba_bitmap_i | input | 64 | Acknowledge bits; bit i refers to index `ba_ssn_i` + i |
| offer_valid_o | output | 1 | A frame is offered for transmission |
| offer_idx_o | output | 8 | Ring index of the offered frame |
| offer_retry_o | output | 1 | The offered frame is a retransmission |
| win_start_o | output | 8 | Ring index of the oldest unacknowledged frame |
| room_o | output | 1 | Window and frame limit allow another new frame |

## Verification
The bench builds the block with its default parameters: an 8-bit ring, a 64-slot window and 7-bit configuration fields. With these values both limits can be reached in a short run. The bench exercises the frame limit of 10, a window size of 12, the clamp of a window size of 100 down to 64, and a window size of 0. Because the ring is only 256 entries deep, a loop of 240 frames carries the window start across the wrap point. The same ring size lets a transmit-done report for index 78 alias slot 14, which exposes any missing window check. Block-acks with set bits outside the window are followed by admission of the aliased frame, so a stale acknowledgement would show up as an early slide of the window start.

// File: rtl/baw_pkg.sv
// Package baw_pkg
// Shared constants for the block-acknowledge window tracker. The modules take
// their own parameters; these values are only their defaults.
package baw_pkg;
    localparam int unsigned DEF_SEQ_W   = 8;   // ring index width
    localparam int unsigned DEF_WIN_MAX = 64;  // slots in the window
    localparam int unsigned DEF_CFG_W   = 7;   // width of configuration fields
endpackage

// File: rtl/baw_slot_update.sv
// Module baw_slot_update
// Computes the next state of every window slot from the current state, one
// transmit-done report, one block-ack event and an accepted retransmission.
// Slots are addressed by the low bits of the ring index. The module assumes
// that slots outside the window are clear. Sliding is not done here.
module baw_slot_update #(
    parameter int unsigned SEQ_W   = baw_pkg::DEF_SEQ_W,
    parameter int unsigned WIN_MAX = baw_pkg::DEF_WIN_MAX,
    localparam int unsigned SLOT_W = $clog2(WIN_MAX),
    localparam int unsigned CNT_W  = SLOT_W + 1
) (
    input  logic [SEQ_W-1:0]   ws,
    input  logic [CNT_W-1:0]   inflight,
    input  logic               txd_valid,
    input  logic [SEQ_W-1:0]   txd_idx,
    input  logic               ba_valid,
    input  logic [SEQ_W-1:0]   ba_ssn,
    input  logic [WIN_MAX-1:0] ba_bitmap,
    input  logic               take_retry,
    input  logic [SLOT_W-1:0]  take_slot,
    input  logic [WIN_MAX-1:0] sent_q,
    input  logic [WIN_MAX-1:0] acked_q,
    input  logic [WIN_MAX-1:0] retry_q,
    output logic [WIN_MAX-1:0] sent_d,
    output logic [WIN_MAX-1:0] acked_d,
    output logic [WIN_MAX-1:0] retry_d
);
    for (genvar s = 0; s < WIN_MAX; s++) begin : g_slot
        logic [SLOT_W-1:0] off;
        logic [SEQ_W-1:0]  idx;
        logic [SEQ_W-1:0]  pos;
        logic              inwin;
        logic              covered;

        // Position of this slot inside the window and inside the bitmap
        always_comb begin
            off     = SLOT_W'(s) - ws[SLOT_W-1:0];
            idx     = ws + SEQ_W'(off);
            pos     = idx - ba_ssn;
            inwin   = {1'b0, off} < inflight;
            covered = ba_valid && inwin && (pos < SEQ_W'(WIN_MAX));
        end

        // Applies done report, then block-ack, then retransmission accept
        always_comb begin
            sent_d[s]  = sent_q[s];
            acked_d[s] = acked_q[s];
            retry_d[s] = retry_q[s];
            if (txd_valid && inwin && txd_idx == idx && !acked_q[s]) begin
                sent_d[s] = 1'b1;
            end
            if (covered) begin
                if (ba_bitmap[pos[SLOT_W-1:0]]) begin
                    acked_d[s] = 1'b1;
                    retry_d[s] = 1'b0;
                    sent_d[s]  = 1'b0;
                end else if (sent_d[s] && !acked_d[s]) begin
                    retry_d[s] = 1'b1;
                    sent_d[s]  = 1'b0;
                end
            end
            if (take_retry && take_slot == SLOT_W'(s)) begin
                retry_d[s] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/baw_lead_run.sv
// Module baw_lead_run
// Counts the acknowledged frames that sit at the head of the window without a
// gap. The input vector is already rotated so that bit 0 is the window start.
module baw_lead_run #(
    parameter int unsigned WIN_MAX = baw_pkg::DEF_WIN_MAX,
    localparam int unsigned CNT_W  = $clog2(WIN_MAX) + 1
) (
    input  logic [WIN_MAX-1:0] rot_acked,
    input  logic [CNT_W-1:0]   inflight,
    output logic [CNT_W-1:0]   run
);
    // Walks from the head and stops at the first gap
    always_comb begin
        logic alive;
        alive = 1'b1;
        run   = '0;
        for (int o = 0; o < int'(WIN_MAX); o++) begin
            if (alive && rot_acked[o] && (CNT_W'(o) < inflight)) begin
                run = run + 1'b1;
            end else begin
                alive = 1'b0;
            end
        end
    end
endmodule

// File: rtl/baw_oldest_pick.sv
// Module baw_oldest_pick
// Finds the frame nearest the window start that waits for retransmission.
// The input vector is rotated so that bit 0 is the window start.
module baw_oldest_pick #(
    parameter int unsigned WIN_MAX = baw_pkg::DEF_WIN_MAX,
    localparam int unsigned SLOT_W = $clog2(WIN_MAX),
    localparam int unsigned CNT_W  = SLOT_W + 1
) (
    input  logic [WIN_MAX-1:0] rot_retry,
    input  logic [CNT_W-1:0]   inflight,
    output logic               found,
    output logic [SLOT_W-1:0]  off
);
    // Scans downward so the smallest offset wins
    always_comb begin
        found = 1'b0;
        off   = '0;
        for (int o = int'(WIN_MAX) - 1; o >= 0; o--) begin
            if (rot_retry[o] && (CNT_W'(o) < inflight)) begin
                found = 1'b1;
                off   = SLOT_W'(o);
            end
        end
    end
endmodule

// File: rtl/baw_tracker.sv
// Module baw_tracker
// Per-queue block-acknowledge window tracker. It holds the window start, the
// issue pointer, the enqueue pointer and three status bits per slot. Each cycle
// it offers either the oldest frame that waits for retransmission or the next
// queued frame. Assumptions: the host never queues more than the ring holds,
// and the scheduler asserts take_i only while offer_valid_o is high.
module baw_tracker #(
    parameter int unsigned SEQ_W   = baw_pkg::DEF_SEQ_W,
    parameter int unsigned WIN_MAX = baw_pkg::DEF_WIN_MAX,
    parameter int unsigned CFG_W   = baw_pkg::DEF_CFG_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CFG_W-1:0]   win_size_i,
    input  logic [CFG_W-1:0]   frame_limit_i,
    input  logic               enq_i,
    input  logic               take_i,
    input  logic               txd_valid_i,
    input  logic [SEQ_W-1:0]   txd_idx_i,
    input  logic               ba_valid_i,
    input  logic [SEQ_W-1:0]   ba_ssn_i,
    input  logic [WIN_MAX-1:0] ba_bitmap_i,
    output logic               offer_valid_o,
    output logic [SEQ_W-1:0]   offer_idx_o,
    output logic               offer_retry_o,
    output logic [SEQ_W-1:0]   win_start_o,
    output logic               room_o
);
    localparam int unsigned SLOT_W = $clog2(WIN_MAX);
    localparam int unsigned CNT_W  = SLOT_W + 1;
    localparam int unsigned CMP_W  = CFG_W + 1;

    logic [SEQ_W-1:0]   ws_q, nxt_q, wr_q;
    logic [WIN_MAX-1:0] sent_q, acked_q, retry_q;
    logic [WIN_MAX-1:0] sent_d, acked_d, retry_d;
    logic [WIN_MAX-1:0] rot_acked_d, rot_retry_q, slide_clr;
    logic [CNT_W-1:0]   inflight, run;
    logic [CMP_W-1:0]   inflight_x, eff_win_x;
    logic               retry_found, backlog, take_new, take_retry;
    logic [SLOT_W-1:0]  retry_off, take_slot;

    // Frames in flight and the admission limits
    always_comb begin
        inflight   = CNT_W'(nxt_q - ws_q);
        inflight_x = CMP_W'(inflight);
        eff_win_x  = (win_size_i > CFG_W'(WIN_MAX)) ? CMP_W'(WIN_MAX) : {1'b0, win_size_i};
        room_o     = (inflight_x < eff_win_x) && (inflight_x < {1'b0, frame_limit_i});
        backlog    = (wr_q != nxt_q);
    end

    // Rotates slot vectors so bit 0 is the window start; marks slots that slide out
    for (genvar o = 0; o < WIN_MAX; o++) begin : g_rot
        logic [SLOT_W-1:0] s_idx;
        logic [SLOT_W-1:0] s_off;
        always_comb begin
            s_idx          = ws_q[SLOT_W-1:0] + SLOT_W'(o);
            rot_acked_d[o] = acked_d[s_idx];
            rot_retry_q[o] = retry_q[s_idx];
            s_off          = SLOT_W'(o) - ws_q[SLOT_W-1:0];
            slide_clr[o]   = {1'b0, s_off} < run;
        end
    end

    baw_oldest_pick #(.WIN_MAX(WIN_MAX)) u_pick (
        .rot_retry (rot_retry_q),
        .inflight  (inflight),
        .found     (retry_found),
        .off       (retry_off)
    );

    // Offer selection: retransmission first, then a new frame
    always_comb begin
        offer_retry_o = retry_found;
        offer_valid_o = retry_found || (room_o && backlog);
        offer_idx_o   = retry_found ? (ws_q + SEQ_W'(retry_off)) : nxt_q;
        take_retry    = take_i && retry_found;
        take_new      = take_i && !retry_found && room_o && backlog;
        take_slot     = ws_q[SLOT_W-1:0] + retry_off;
        win_start_o   = ws_q;
    end

    baw_slot_update #(.SEQ_W(SEQ_W), .WIN_MAX(WIN_MAX)) u_upd (
        .ws         (ws_q),
        .inflight   (inflight),
        .txd_valid  (txd_valid_i),
        .txd_idx    (txd_idx_i),
        .ba_valid   (ba_valid_i),
        .ba_ssn     (ba_ssn_i),
        .ba_bitmap  (ba_bitmap_i),
        .take_retry (take_retry),
        .take_slot  (take_slot),
        .sent_q     (sent_q),
        .acked_q    (acked_q),
        .retry_q    (retry_q),
        .sent_d     (sent_d),
        .acked_d    (acked_d),
        .retry_d    (retry_d)
    );

    baw_lead_run #(.WIN_MAX(WIN_MAX)) u_run (
        .rot_acked (rot_acked_d),
        .inflight  (inflight),
        .run       (run)
    );

    // State registers: pointers advance, slid-out slots are cleared
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_q    <= '0;
            nxt_q   <= '0;
            wr_q    <= '0;
            sent_q  <= '0;
            acked_q <= '0;
            retry_q <= '0;
        end else begin
            ws_q    <= ws_q + SEQ_W'(run);
            if (take_new) nxt_q <= nxt_q + 1'b1;
            if (enq_i)    wr_q  <= wr_q + 1'b1;
            sent_q  <= sent_d  & ~slide_clr;
            acked_q <= acked_d & ~slide_clr;
            retry_q <= retry_d & ~slide_clr;
        end
    end
endmodule

// File: rtl/baw_tracker_chk.sv
// Module baw_tracker_chk
// Temporal checks on the tracker's ports and its in-flight count.
// It is attached to every baw_tracker instance by the bind below.
module baw_tracker_chk #(
    parameter int unsigned SEQ_W   = baw_pkg::DEF_SEQ_W,
    parameter int unsigned WIN_MAX = baw_pkg::DEF_WIN_MAX,
    localparam int unsigned CNT_W  = $clog2(WIN_MAX) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ba_valid_i,
    input logic             offer_valid_o,
    input logic             offer_retry_o,
    input logic [SEQ_W-1:0] offer_idx_o,
    input logic [SEQ_W-1:0] win_start_o,
    input logic             room_o,
    input logic [CNT_W-1:0] inflight
);
    logic past_ok;

    // Marks that one cycle after reset has been seen
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        inflight <= CNT_W'(WIN_MAX));

    a_r3_new_needs_room: assert property (@(posedge clk) disable iff (!rst_n)
        (offer_valid_o && !offer_retry_o) |-> room_o);

    a_r2_new_at_window_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (offer_valid_o && !offer_retry_o) |-> (offer_idx_o == win_start_o + SEQ_W'(inflight)));

    a_r6_retry_inside_window: assert property (@(posedge clk) disable iff (!rst_n)
        offer_retry_o |-> (offer_valid_o && (SEQ_W'(offer_idx_o - win_start_o) < SEQ_W'(inflight))));

    a_r5_slide_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && win_start_o != $past(win_start_o)) |-> $past(ba_valid_i));

    a_r5_slide_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (SEQ_W'(win_start_o - $past(win_start_o)) <= SEQ_W'(WIN_MAX)));
endmodule

bind baw_tracker baw_tracker_chk #(.SEQ_W(SEQ_W), .WIN_MAX(WIN_MAX)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ba_valid_i    (ba_valid_i),
    .offer_valid_o (offer_valid_o),
    .offer_retry_o (offer_retry_o),
    .offer_idx_o   (offer_idx_o),
    .win_start_o   (win_start_o),
    .room_o        (room_o),
    .inflight      (inflight)
);

// File: tb/baw_tracker_tb.sv
`timescale 1ns/1ps
// Bench for baw_tracker: a vector table followed by directed corner cases.
module baw_tracker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  win_size = 7'd64;
    logic [6:0]  frame_limit = 7'd10;
    logic        enq = 1'b0, take = 1'b0, txd_valid = 1'b0, ba_valid = 1'b0;
    logic [7:0]  txd_idx = '0, ba_ssn = '0;
    logic [63:0] ba_bitmap = '0;
    logic        offer_valid, offer_retry, room;
    logic [7:0]  offer_idx, win_start;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    baw_tracker dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .win_size_i    (win_size),
        .frame_limit_i (frame_limit),
        .enq_i         (enq),
        .take_i        (take),
        .txd_valid_i   (txd_valid),
        .txd_idx_i     (txd_idx),
        .ba_valid_i    (ba_valid),
        .ba_ssn_i      (ba_ssn),
        .ba_bitmap_i   (ba_bitmap),
        .offer_valid_o (offer_valid),
        .offer_idx_o   (offer_idx),
        .offer_retry_o (offer_retry),
        .win_start_o   (win_start),
        .room_o        (room)
    );

    localparam logic [2:0] OP_NOP = 3'd0, OP_ENQ = 3'd1, OP_TAKE = 3'd2, OP_TXD = 3'd3, OP_BA = 3'd4;

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  op;
        logic [7:0]  arg;
        logic [15:0] bm;
        logic        ov;
        logic [7:0]  oidx;
        logic        ort;
        logic [7:0]  ws;
        logic        rm;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{4'd1, OP_NOP,  8'd0, 16'h0000, 1'b0, 8'd0, 1'b0, 8'd0, 1'b1}, // R1 reset state
        '{4'd2, OP_ENQ,  8'd0, 16'h0000, 1'b1, 8'd0, 1'b0, 8'd0, 1'b1}, // R2
        '{4'd2, OP_ENQ,  8'd0, 16'h0000, 1'b1, 8'd0, 1'b0, 8'd0, 1'b1},
        '{4'd2, OP_ENQ,  8'd0, 16'h0000, 1'b1, 8'd0, 1'b0, 8'd0, 1'b1},
        '{4'd2, OP_ENQ,  8'd0, 16'h0000, 1'b1, 8'd0, 1'b0, 8'd0, 1'b1},
        '{4'd2, OP_TAKE, 8'd0, 16'h0000, 1'b1, 8'd1, 1'b0, 8'd0, 1'b1}, // R2 order
        '{4'd2, OP_TAKE, 8'd0, 16'h0000, 1'b1, 8'd2, 1'b0, 8'd0, 1'b1},
        '{4'd2, OP_TAKE, 8'd0, 16'h0000, 1'b1, 8'd3, 1'b0, 8'd0, 1'b1},
        '{4'd2, OP_TAKE, 8'd0, 16'h0000, 1'b0, 8'd0, 1'b0, 8'd0, 1'b1}, // queue drained
        '{4'd7, OP_TXD,  8'd0, 16'h0000, 1'b0, 8'd0, 1'b0, 8'd0, 1'b1},
        '{4'd7, OP_TXD,  8'd1, 16'h0000, 1'b0, 8'd0, 1'b0, 8'd0, 1'b1},
        '{4'd7, OP_TXD,  8'd2, 16'h0000, 1'b0, 8'd0, 1'b0, 8'd0, 1'b1},
        '{4'd6, OP_BA,   8'd0, 16'h0006, 1'b1, 8'd0, 1'b1, 8'd0, 1'b1}, // R6 frame 0 retried, R7 frame 3 not, R5 no slide
        '{4'd6, OP_TAKE, 8'd0, 16'h0000, 1'b0, 8'd0, 1'b0, 8'd0, 1'b1},
        '{4'd6, OP_TXD,  8'd0, 16'h0000, 1'b0, 8'd0, 1'b0, 8'd0, 1'b1},
        '{4'd5, OP_BA,   8'd0, 16'h0001, 1'b0, 8'd0, 1'b0, 8'd3, 1'b1}, // R5 slide over 0..2
        '{4'd5, OP_TXD,  8'd3, 16'h0000, 1'b0, 8'd0, 1'b0, 8'd3, 1'b1},
        '{4'd5, OP_BA,   8'd3, 16'h0001, 1'b0, 8'd0, 1'b0, 8'd4, 1'b1},
        '{4'd4, OP_BA,   8'd4, 16'hFFFF, 1'b0, 8'd0, 1'b0, 8'd4, 1'b1}  // R4 empty window ignores bits
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_enq();
        enq = 1'b1; @(negedge clk); enq = 1'b0;
    endtask
    task automatic do_take();
        take = 1'b1; @(negedge clk); take = 1'b0;
    endtask
    task automatic do_txd(input logic [7:0] idx);
        txd_valid = 1'b1; txd_idx = idx; @(negedge clk); txd_valid = 1'b0;
    endtask
    task automatic do_ba(input logic [7:0] ssn, input logic [63:0] bm);
        ba_valid = 1'b1; ba_ssn = ssn; ba_bitmap = bm; @(negedge clk); ba_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        int taken;
        int errs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[v].req, v);
            case (VEC[v].op)
                OP_ENQ:  do_enq();
                OP_TAKE: do_take();
                OP_TXD:  do_txd(VEC[v].arg);
                OP_BA:   do_ba(VEC[v].arg, {48'h0, VEC[v].bm});
                default: @(negedge clk);
            endcase
            chk({tag, " valid"}, 32'(offer_valid), 32'(VEC[v].ov));
            if (VEC[v].ov) begin
                chk({tag, " idx"}, 32'(offer_idx), 32'(VEC[v].oidx));
                chk({tag, " retry"}, 32'(offer_retry), 32'(VEC[v].ort));
            end
            chk({tag, " start"}, 32'(win_start), 32'(VEC[v].ws));
            chk({tag, " room"}, 32'(room), 32'(VEC[v].rm));
        end

        // R3: frame limit of 10 stops admission; R2 indices stay consecutive
        repeat (12) do_enq();
        taken = 0; errs = 0;
        while (offer_valid && taken < 20) begin
            if (offer_idx != 8'(4 + taken)) errs++;
            do_take();
            taken++;
        end
        chk("R2 consecutive new indices", 32'(errs), 0);
        chk("R3 frames admitted under limit", 32'(taken), 10);
        chk("R3 room at limit", 32'(room), 0);

        // R9: window size 100 acts as 64, window size 0 blocks
        frame_limit = 7'd127; win_size = 7'd100; @(negedge clk);
        chk("R9 oversize window clamps", 32'(room), 1);
        win_size = 7'd0; @(negedge clk);
        chk("R9 zero window", 32'(room), 0);
        win_size = 7'd64; frame_limit = 7'd10; @(negedge clk);

        // R5: out-of-order ack does not slide; R4: out-of-window bits ignored
        do_ba(8'd9, 64'h1);
        chk("R5 out-of-order ack keeps start", 32'(win_start), 4);
        do_ba(8'd14, 64'hFFFF);
        chk("R4 bits past window ignored", 32'(win_start), 4);
        do_ba(8'd4, 64'h1F);
        chk("R5 slide over 4..9", 32'(win_start), 10);
        chk("R3 room after slide", 32'(room), 1);
        chk("R2 next new index", 32'(offer_idx), 14);
        do_take();
        do_ba(8'd10, 64'hF);
        chk("R4 no stale ack on frame 14", 32'(win_start), 14);

        // R10: done report aliasing slot 14 from outside the window
        do_txd(8'd78);
        do_ba(8'd14, 64'h0);
        chk("R10 alias done ignored", 32'(offer_retry), 0);
        chk("R7 unsent frame not retried", 32'(offer_idx), 15);

        // R6: retransmission goes ahead of queued new frame
        do_txd(8'd14);
        do_ba(8'd14, 64'h0);
        chk("R6 retry flag", 32'(offer_retry), 1);
        chk("R6 retry index", 32'(offer_idx), 14);
        do_take();
        chk("R6 new after retry", 32'(offer_idx), 15);
        do_txd(8'd14);
        do_ba(8'd14, 64'h1);
        chk("R5 slide to 15", 32'(win_start), 15);

        // R6: oldest retransmission first
        do_take();
        do_enq(); do_enq();
        do_take(); do_take();
        do_txd(8'd15); do_txd(8'd16); do_txd(8'd17);
        do_ba(8'd15, 64'h2);
        chk("R6 oldest retry first", 32'(offer_idx), 15);
        do_take();
        chk("R6 second retry", 32'(offer_idx), 17);
        chk("R6 second retry flag", 32'(offer_retry), 1);
        do_take();
        chk("R6 nothing left", 32'(offer_valid), 0);
        do_txd(8'd15); do_txd(8'd17);
        do_ba(8'd15, 64'h5);
        chk("R7 acked frame 16 kept by zero bit", 32'(win_start), 18);

        // R8: ring wrap over 240 frames
        errs = 0;
        for (int k = 0; k < 240; k++) begin
            logic [7:0] e;
            e = 8'(18 + k);
            do_enq();
            if (!offer_valid || offer_idx != e || offer_retry) errs++;
            do_take();
            do_txd(e);
            do_ba(e, 64'h1);
            if (win_start != 8'(e + 1)) errs++;
        end
        chk("R8 wrap sequence", 32'(errs), 0);
        chk("R8 start after wrap", 32'(win_start), 2);

        // R3/R9: window size 12 is the binding limit
        win_size = 7'd12; frame_limit = 7'd127;
        repeat (13) do_enq();
        taken = 0;
        while (offer_valid && taken < 20) begin
            do_take();
            taken++;
        end
        chk("R3 window size bounds flight", 32'(taken), 12);
        chk("R3 room at window size", 32'(room), 0);

        // R1: reset in mid-flight
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 start after reset", 32'(win_start), 0);
        chk("R1 no offer after reset", 32'(offer_valid), 0);
        chk("R1 room after reset", 32'(room), 1);

        finish_run();
    end
endmodule